// File: doc/BRIEF.md
# Threshold-Driven SMBus Receive Buffer

This block sits between the byte-level receiver of an SMBus/I2C master and the host. It holds received bytes in a small ring buffer and fills that buffer in bursts. A burst is started by the bus engine, by a host read of an empty buffer, or by the host acknowledging the threshold flag. It pulls one byte at a time from the bus engine until the stored count equals a programmed threshold. A burst also stops once the buffer is full. The host then drains the bytes one per read strobe. Reads return bytes in arrival order.

When a burst ends at the threshold, the block raises a threshold flag. It can also ask the bus engine to NACK the final byte, and it sets a data-ready flag whose behaviour depends on whether the host enabled the threshold interrupt. A threshold larger than the buffer stops the burst at full capacity and produces an error pulse. During the stop phase of a read, host reads drain the remaining bytes and request the STOP condition once at most one byte is left.

Top module: `smb_rx_thresh_fifo`

## Requirements
- R1: Storage is DEPTH (16) bytes used as a ring. Host reads return bytes in the order they were stored, across wrap-around of the read position.
- R2: A burst raises `byte_req` and stores `byte_data` on each cycle with `byte_vld` high. It stops requesting when the count reaches the threshold or DEPTH. A burst trigger while the count already equals the threshold does nothing: no request is raised and no flag changes.
- R3: `thr_hit` goes high when a burst ends with the count at or above the threshold. It is cleared when a burst starts and when `flag_clr` is pulsed.
- R4: With a threshold above DEPTH, a burst stops at DEPTH bytes. `thr_hit` stays low and `thr_err` pulses high for one cycle.
- R5: A burst ending at the threshold while the last-byte control is set pulses `nack_req` for one cycle. On the same edge it clears the last-byte control, which is visible on `ctl_last_o`.
- R6: When a burst ends at the threshold with a full buffer, `data_rdy` and `fifo_rdy` are set. Otherwise `data_rdy` becomes the inverse of the interrupt enable. Any pop clears `fifo_rdy`, and a pop that empties the buffer clears `data_rdy`.
- R7: A host read while receiving with count 0 starts a burst. With a nonzero count, it pops one byte, which appears on `rd_data` one cycle later, and decrements the count.
- R8: `flag_clr` while `rx_active` is high also starts a burst.
- R9: A control write with `ctl_last` at 1 sets the last-byte control. A write with `ctl_last` at 0 leaves it unchanged.
- R10: After reset the threshold is 1, interrupt enable and last-byte control are 0, and the count, flags and pulses are 0.
- R11: While `rx_stopping` is high, a host read pulses `stop_req` when the count is 1 or less. A read with count 0 leaves the count and `rd_data` unchanged.
- R12: Host reads while neither receiving nor stopping, and host reads or triggers during a burst, change neither the count nor `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_active | input | 1 | Controller is in a receive transfer |
| rx_stopping | input | 1 | Controller is stopping the final receive |
| fill_go | input | 1 | Burst trigger from the bus engine |
| host_rd | input | 1 | Host data-read strobe |
| flag_clr | input | 1 | Host write-one-to-clear of the threshold flag |
| ctl_we | input | 1 | Receive control write strobe |
| ctl_thr | input | 5 | Threshold value written |
| ctl_last | input | 1 | Last-byte control written (set only) |
| ctl_ie | input | 1 | Threshold interrupt enable written |
| byte_req | output | 1 | Request one byte from the bus engine |
| byte_vld | input | 1 | Bus engine delivers a byte |
| byte_data | input | 8 | Delivered byte |
| rd_data | output | 8 | Last popped byte |
| byte_count | output | 5 | Bytes held |
| thr_hit | output | 1 | Threshold-reached flag |
| thr_err | output | 1 | Threshold-too-large pulse |
| nack_req | output | 1 | NACK request pulse to the bus engine |
| data_rdy | output | 1 | Data-ready flag |
| fifo_rdy | output | 1 | Full-buffer ready flag |
| stop_req | output | 1 | STOP request pulse |
| ctl_last_o | output | 1 | Current last-byte control |

## Verification
The assertions assume that the host never writes the control with the last-byte bit set in the same cycle that a burst ends. They also assume that `rx_active` and `rx_stopping` are never high together, and that a host read never coincides with another burst trigger. The stimulus respects these conditions by issuing every strobe alone, one cycle wide, with an idle cycle after it. It also switches the transfer mode only while no burst runs. The bus source answers requests with varying gaps, so the one-byte-at-a-time handshake is checked under stalls.

// File: rtl/smb_rxq_pkg.sv
package smb_rxq_pkg;
  localparam int RXQ_DEPTH  = 16;
  localparam int RXQ_DATA_W = 8;

  typedef enum logic [0:0] {
    FS_IDLE = 1'b0,
    FS_FILL = 1'b1
  } fill_st_e;
endpackage

// File: rtl/smb_rxq_ring.sv
module smb_rxq_ring #(
  parameter  int DEPTH  = 16,
  parameter  int DATA_W = 8,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic [CNT_W-1:0]  count_o,
  output logic [DATA_W-1:0] head_o
);
  // DEPTH is a power of two so pointer wrap is plain truncation.
  logic [PTR_W-1:0] rptr_q, rptr_d, wptr;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DEPTH-1:0][DATA_W-1:0] slot_w;

  assign wptr = rptr_q + cnt_q[PTR_W-1:0];

  always_comb begin
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (pop) begin
      rptr_d = rptr_q + PTR_W'(1);
      cnt_d  = cnt_q - CNT_W'(1);
    end else if (wr_en) begin
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (pop || wr_en) begin
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic [DATA_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wptr == PTR_W'(e))) begin
        byte_q <= wr_data;
      end
    end
    assign slot_w[e] = byte_q;
  end

  assign head_o  = slot_w[rptr_q];
  assign count_o = cnt_q;

  // R1: the count never exceeds the ring size
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R7: a pop is never taken from an empty ring
  assert_no_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
  // R2: no byte is stored into a full ring
  assert_no_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/smb_rxq_fill_fsm.sv
module smb_rxq_fill_fsm
  import smb_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] thr,
  output logic             busy,
  output logic             byte_req,
  output logic             fill_begin,
  output logic             done_hit,
  output logic             done_err
);
  fill_st_e state_q, state_d;
  logic     need;

  assign need = (count < thr) && (count < CNT_W'(DEPTH));

  always_comb begin
    state_d    = state_q;
    fill_begin = 1'b0;
    done_hit   = 1'b0;
    done_err   = 1'b0;
    case (state_q)
      FS_IDLE: begin
        if (start && (count != thr)) begin
          state_d    = FS_FILL;
          fill_begin = 1'b1;
        end
      end
      FS_FILL: begin
        if (!need) begin
          state_d  = FS_IDLE;
          done_hit = (count >= thr);
          done_err = (count < thr);
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign busy     = (state_q == FS_FILL);
  assign byte_req = busy && need;

  // R4: an error ending only happens with a completely full ring
  assert_err_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> count == CNT_W'(DEPTH));
  // R2: a burst never begins when the count already sits at the threshold
  assert_noop_at_thr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && count == thr) |=> !busy);
endmodule

// File: rtl/smb_rxq_ctl.sv
module smb_rxq_ctl #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CNT_W-1:0] thr_in,
  input  logic             last_in,
  input  logic             ie_in,
  input  logic             last_clr,
  output logic [CNT_W-1:0] thr_o,
  output logic             ie_o,
  output logic             last_o
);
  logic [CNT_W-1:0] thr_q, thr_d;
  logic             ie_q, ie_d, last_q, last_d;

  always_comb begin
    thr_d  = thr_q;
    ie_d   = ie_q;
    last_d = last_q;
    if (last_clr) last_d = 1'b0;
    if (we) begin
      thr_d = thr_in;
      ie_d  = ie_in;
      if (last_in) last_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= CNT_W'(1);
      ie_q   <= 1'b0;
      last_q <= 1'b0;
    end else begin
      if (we) begin
        thr_q <= thr_d;
        ie_q  <= ie_d;
      end
      if (we || last_clr) last_q <= last_d;
    end
  end

  assign thr_o  = thr_q;
  assign ie_o   = ie_q;
  assign last_o = last_q;

  // R9: software alone cannot clear the last-byte control
  assert_last_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(last_q) |-> $past(last_clr));
endmodule

// File: rtl/smb_rx_thresh_fifo.sv
module smb_rx_thresh_fifo
  import smb_rxq_pkg::*;
#(
  parameter  int DEPTH  = RXQ_DEPTH,
  parameter  int DATA_W = RXQ_DATA_W,
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_active,
  input  logic              rx_stopping,
  input  logic              fill_go,
  input  logic              host_rd,
  input  logic              flag_clr,
  input  logic              ctl_we,
  input  logic [CNT_W-1:0]  ctl_thr,
  input  logic              ctl_last,
  input  logic              ctl_ie,
  output logic              byte_req,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  byte_count,
  output logic              thr_hit,
  output logic              thr_err,
  output logic              nack_req,
  output logic              data_rdy,
  output logic              fifo_rdy,
  output logic              stop_req,
  output logic              ctl_last_o
);
  // Reset asserts asynchronously and is released on a clock edge.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [CNT_W-1:0]  count, thr;
  logic [DATA_W-1:0] head;
  logic ie, last, busy, fill_begin, done_hit, done_err;
  logic rd_ok, pop, rd_fill, start, stop_d, wr_en;
  logic hit_q, hit_d, err_q, nack_q, nack_d, drdy_q, drdy_d, frdy_q, frdy_d, stop_q;
  logic [DATA_W-1:0] rd_q;

  assign rd_ok   = host_rd && !busy && (rx_active || rx_stopping);
  assign pop     = rd_ok && (count != '0);
  assign stop_d  = rd_ok && rx_stopping && (count <= CNT_W'(1));
  assign rd_fill = rd_ok && !rx_stopping && (count == '0);
  assign start   = !busy && !pop && (fill_go || (flag_clr && rx_active) || rd_fill);
  assign wr_en   = byte_req && byte_vld;
  assign nack_d  = done_hit && last;

  smb_rxq_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ring (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (wr_en),
    .wr_data (byte_data),
    .pop     (pop),
    .count_o (count),
    .head_o  (head)
  );

  smb_rxq_fill_fsm #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .start      (start),
    .count      (count),
    .thr        (thr),
    .busy       (busy),
    .byte_req   (byte_req),
    .fill_begin (fill_begin),
    .done_hit   (done_hit),
    .done_err   (done_err)
  );

  smb_rxq_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .we       (ctl_we),
    .thr_in   (ctl_thr),
    .last_in  (ctl_last),
    .ie_in    (ctl_ie),
    .last_clr (nack_d),
    .thr_o    (thr),
    .ie_o     (ie),
    .last_o   (last)
  );

  always_comb begin
    hit_d  = hit_q;
    drdy_d = drdy_q;
    frdy_d = frdy_q;
    if (flag_clr || fill_begin) hit_d = 1'b0;
    if (pop) begin
      frdy_d = 1'b0;
      if (count == CNT_W'(1)) drdy_d = 1'b0;
    end
    if (done_hit) begin
      hit_d = 1'b1;
      if (count == CNT_W'(DEPTH)) begin
        drdy_d = 1'b1;
        frdy_d = 1'b1;
      end else begin
        drdy_d = !ie;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      hit_q  <= 1'b0;
      drdy_q <= 1'b0;
      frdy_q <= 1'b0;
      err_q  <= 1'b0;
      nack_q <= 1'b0;
      stop_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      hit_q  <= hit_d;
      drdy_q <= drdy_d;
      frdy_q <= frdy_d;
      err_q  <= done_err;
      nack_q <= nack_d;
      stop_q <= stop_d;
      if (pop) rd_q <= head;
    end
  end

  assign rd_data    = rd_q;
  assign byte_count = count;
  assign thr_hit    = hit_q;
  assign thr_err    = err_q;
  assign nack_req   = nack_q;
  assign data_rdy   = drdy_q;
  assign fifo_rdy   = frdy_q;
  assign stop_req   = stop_q;
  assign ctl_last_o = last;

  // R3: the flag only rises once the count has reached the threshold
  assert_hit_at_thr_R3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(hit_q) |-> $past(count) >= $past(thr));
  // R5: a NACK request leaves the last-byte control cleared
  assert_nack_clears_last_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    nack_q |-> !last);
  // R11: STOP is requested only with at most one byte left
  assert_stop_low_count_R11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    stop_q |-> $past(count) <= CNT_W'(1));
  // R4: the error pulse never comes with the threshold flag rising
  assert_err_no_hit_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    err_q |-> !$rose(hit_q));
endmodule

// File: tb/sim_smb_rx_thresh_fifo.sv
`timescale 1ns/1ps
module sim_smb_rx_thresh_fifo;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic rx_active = 0, rx_stopping = 0, fill_go = 0, host_rd = 0, flag_clr = 0;
  logic ctl_we = 0, ctl_last = 0, ctl_ie = 0, byte_vld = 0;
  logic [4:0] ctl_thr = 0;
  logic [7:0] byte_data = 0;
  logic byte_req, thr_hit, thr_err, nack_req, data_rdy, fifo_rdy, stop_req, ctl_last_o;
  logic [7:0] rd_data;
  logic [4:0] byte_count;

  smb_rx_thresh_fifo u0 (
    .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .rx_stopping(rx_stopping),
    .fill_go(fill_go), .host_rd(host_rd), .flag_clr(flag_clr), .ctl_we(ctl_we),
    .ctl_thr(ctl_thr), .ctl_last(ctl_last), .ctl_ie(ctl_ie), .byte_req(byte_req),
    .byte_vld(byte_vld), .byte_data(byte_data), .rd_data(rd_data),
    .byte_count(byte_count), .thr_hit(thr_hit), .thr_err(thr_err),
    .nack_req(nack_req), .data_rdy(data_rdy), .fifo_rdy(fifo_rdy),
    .stop_req(stop_req), .ctl_last_o(ctl_last_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // Behavioural reference: a byte queue plus flags, stepped on each edge.
  byte unsigned m_q[$];
  bit m_fill, m_ie, m_last, m_hit, m_drdy, m_frdy, m_nack, m_err, m_stop;
  int m_thr = 1;
  int m_rd;

  always @(posedge clk) begin
    int sz;
    bit rd_ok, popit, begin_f;
    if (!rst_n) begin
      m_q.delete(); m_fill = 0; m_ie = 0; m_last = 0; m_hit = 0; m_drdy = 0;
      m_frdy = 0; m_nack = 0; m_err = 0; m_stop = 0; m_thr = 1; m_rd = 0;
    end else begin
      sz = m_q.size();
      m_nack = 0; m_err = 0; m_stop = 0; begin_f = 0; popit = 0;
      if (flag_clr) m_hit = 0;
      if (m_fill) begin
        if (sz < m_thr && sz < 16) begin
          if (byte_vld) m_q.push_back(byte_data);
        end else begin
          m_fill = 0;
          if (sz >= m_thr) begin
            m_hit = 1;
            if (m_last) begin m_nack = 1; m_last = 0; end
            if (sz == 16) begin m_drdy = 1; m_frdy = 1; end
            else m_drdy = !m_ie;
          end else m_err = 1;
        end
      end else begin
        rd_ok = host_rd && (rx_active || rx_stopping);
        if (rd_ok && rx_stopping && sz <= 1) m_stop = 1;
        if (rd_ok && sz > 0) begin
          popit = 1;
          m_rd = m_q.pop_front();
          m_frdy = 0;
          if (sz == 1) m_drdy = 0;
        end
        if (!popit && (fill_go || (flag_clr && rx_active) ||
                       (rd_ok && !rx_stopping && sz == 0)) && sz != m_thr) begin
          m_fill = 1; begin_f = 1;
        end
        if (begin_f) m_hit = 0;
      end
      if (ctl_we) begin
        m_thr = ctl_thr; m_ie = ctl_ie;
        if (ctl_last) m_last = 1;
      end
    end
  end

  // Cycle-by-cycle comparison away from the edge.
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R1 count", byte_count, m_q.size());
      chk("R7 rd_data", rd_data, m_rd);
      chk("R2 byte_req", byte_req, m_fill && m_q.size() < m_thr && m_q.size() < 16);
      chk("R3 thr_hit", thr_hit, m_hit);
      chk("R4 thr_err", thr_err, m_err);
      chk("R5 nack_req", nack_req, m_nack);
      chk("R6 data_rdy", data_rdy, m_drdy);
      chk("R6 fifo_rdy", fifo_rdy, m_frdy);
      chk("R11 stop_req", stop_req, m_stop);
      chk("R9 ctl_last_o", ctl_last_o, m_last);
    end
  end

  // Bus byte source with varying gaps.
  int src_val = 0, gap = 0;
  always @(negedge clk) begin
    byte_vld = 0;
    if (rst_n && byte_req) begin
      if (gap == 0) begin
        byte_vld = 1; byte_data = 8'(src_val); src_val++; gap = src_val % 3;
      end else gap--;
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      wrap_up();
    end
  end

  task automatic go();   @(negedge clk) fill_go = 1;  @(negedge clk) fill_go = 0;  endtask
  task automatic rd();   @(negedge clk) host_rd = 1;  @(negedge clk) host_rd = 0;  endtask
  task automatic clr();  @(negedge clk) flag_clr = 1; @(negedge clk) flag_clr = 0; endtask
  task automatic ctlw(input int t, input bit l, input bit ie);
    @(negedge clk) begin ctl_we = 1; ctl_thr = 5'(t); ctl_last = l; ctl_ie = ie; end
    @(negedge clk) ctl_we = 0;
  endtask
  task automatic settle();
    @(negedge clk);
    while (m_fill) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10 count", byte_count, 0);
    chk("R10 thr_hit", thr_hit, 0);
    chk("R10 last", ctl_last_o, 0);
    chk("R10 data_rdy", data_rdy, 0);
    chk("R10 byte_req", byte_req, 0);

    rx_active = 1;
    go(); settle();
    chk("R10 default threshold 1", byte_count, 1);
    chk("R3 hit", thr_hit, 1);
    chk("R6 ready ie=0", data_rdy, 1);

    rd(); @(negedge clk);
    chk("R7 pop data", rd_data, 0);
    chk("R7 empty count", byte_count, 0);
    chk("R6 ready cleared on empty", data_rdy, 0);

    ctlw(4, 0, 1);
    rd(); settle();
    chk("R7 read on empty fills", byte_count, 4);
    chk("R6 ready clear ie=1", data_rdy, 0);

    go(); settle();
    chk("R2 no-op at threshold", byte_count, 4);
    chk("R2 flag kept", thr_hit, 1);

    clr(); settle();
    chk("R8 flag cleared", thr_hit, 0);

    ctlw(10, 0, 1);
    clr(); settle();
    chk("R8 clear restarts fill", byte_count, 10);
    chk("R8 flag set", thr_hit, 1);

    rd(); rd(); rd(); @(negedge clk);
    chk("R1 order", rd_data, 3);

    ctlw(16, 1, 1);
    ctlw(16, 0, 1);
    chk("R9 last kept", ctl_last_o, 1);

    clr(); settle();
    chk("R6 full count", byte_count, 16);
    chk("R6 fifo_rdy", fifo_rdy, 1);
    chk("R6 data_rdy full", data_rdy, 1);
    chk("R5 last cleared", ctl_last_o, 0);

    for (int i = 0; i < 16; i++) begin
      rd(); @(negedge clk);
      chk("R1 wrap order", rd_data, 4 + i);
    end
    chk("R6 fifo_rdy after pop", fifo_rdy, 0);

    ctlw(20, 1, 0);
    go(); settle();
    chk("R4 stops at 16", byte_count, 16);
    chk("R4 no flag", thr_hit, 0);
    chk("R5 last kept without hit", ctl_last_o, 1);

    rx_active = 0; rx_stopping = 1;
    for (int i = 0; i < 16; i++) begin
      rd();
      chk("R11 stop only near empty", stop_req, (i == 15) ? 1 : 0);
      @(negedge clk);
    end
    rd();
    chk("R11 stop on empty read", stop_req, 1);
    @(negedge clk);
    chk("R11 empty read count", byte_count, 0);
    chk("R11 empty read data", rd_data, 35);

    rx_stopping = 0; rx_active = 1;
    ctlw(3, 0, 0);
    go(); settle();
    rx_active = 0;
    rd(); @(negedge clk);
    chk("R12 idle read count", byte_count, 3);
    chk("R12 idle read data", rd_data, 35);

    rx_active = 1;
    ctlw(9, 0, 0);
    clr();
    rd(); go();
    settle();
    chk("R12 reads during fill", byte_count, 9);
    chk("R12 data during fill", rd_data, 35);

    for (int i = 0; i < 9; i++) rd();
    repeat (3) @(negedge clk);
    chk("R1 drained", byte_count, 0);
    wrap_up();
  end
endmodule